// File: doc/BRIEF.md
# Speculative Load Deferred-Exception Tracker

This block is a register file in which every entry carries a one-bit deferred-exception token next to its data word. A speculative load whose address turned out to be bad does not trap. It writes a poisoned value of zero and sets the token on its destination. Ordinary ALU results take the logical OR of their two source tokens, so the poison follows every dependent value. Nothing happens until an explicit check instruction names a register. If that register's token is set, the block raises a one-cycle recovery redirect that carries the register index. Fix-up code then reloads the value with a plain, non-speculative write, and that write clears the token.

Three write ports can land in the same cycle: speculative load, ALU, and plain write. When two or more name the same destination, a fixed priority decides which one wins. A check sees the token that is being written in the same cycle. A combinational read port exposes the stored data and token of any register. Register 0 always reads as zero with a clear token.

Top module: `dxt_tracker`

## Requirements
- R1: After a synchronous active-low reset, every register reads data 0 and token 0, and `rc_vld` is 0.
- R2: A speculative load with `sl_fault`=0 writes `sl_data` to `sl_dst` and clears that register's token.
- R3: A speculative load with `sl_fault`=1 writes data 0 to `sl_dst` and sets its token, and it causes no redirect by itself.
- R4: An ALU writeback writes `op_data` to `op_dst`. The token it writes is the OR of the stored tokens of `op_src_a` and `op_src_b`, as they stood before that clock edge.
- R5: A plain write writes `nw_data` to `nw_dst` and clears that register's token.
- R6: A check (`ck_vld`=1) on a register whose token is clear gives `rc_vld`=0 in the following cycle.
- R7: A check on a register whose token is set gives `rc_vld`=1 for exactly the following cycle, with `rc_reg` equal to the checked index. Without a further failing check, `rc_vld` returns to 0 one cycle later.
- R8: A check sees the token that any write in the same cycle places on the checked register.
- R9: Register 0 always reads data 0 and token 0. Writes to it are ignored, and a check on it never redirects.
- R10: When several write ports target the same register in one cycle, the plain write wins over the speculative load, and the speculative load wins over the ALU writeback.
- R11: `rp_data` and `rp_tok` show, combinationally, the stored data and token of register `rp_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sl_vld | input | 1 | Speculative load writeback valid |
| sl_dst | input | 5 | Speculative load destination |
| sl_fault | input | 1 | Load address was invalid |
| sl_data | input | 64 | Loaded data |
| op_vld | input | 1 | ALU writeback valid |
| op_dst | input | 5 | ALU destination |
| op_src_a | input | 5 | First ALU source index |
| op_src_b | input | 5 | Second ALU source index |
| op_data | input | 64 | ALU result |
| nw_vld | input | 1 | Plain (non-speculative) write valid |
| nw_dst | input | 5 | Plain write destination |
| nw_data | input | 64 | Plain write data |
| ck_vld | input | 1 | Check request valid |
| ck_reg | input | 5 | Register to check |
| rp_idx | input | 5 | Read port index |
| rp_data | output | 64 | Stored data of `rp_idx` |
| rp_tok | output | 1 | Stored token of `rp_idx` |
| rc_vld | output | 1 | Recovery redirect, one cycle per failing check |
| rc_reg | output | 5 | Index of the register whose check failed |

## Verification
The bench targets five corner cases.

- **Check in the same cycle as a write to the same register.** A design that reads the stale token would miss a freshly poisoned value, or would redirect on a value that is being repaired in that same cycle.
- **Write collisions on one destination.** A wrong priority would let a poisoned load or an ALU result overwrite the recovery reload.
- **ALU sources that include a poisoned register or register 0.** A design that does not propagate would drop the poison. A design that treats register 0 as tokened would create false redirects.
- **Back-to-back checks.** These expose a redirect that sticks high instead of lasting one cycle.
- **Writes and checks on register 0.** These expose a register 0 that is not hardwired.

// File: rtl/dxt_pkg.sv
// Shared definitions for the deferred-exception tracker.
// Assumes: nothing beyond IEEE 1800-2017.
package dxt_pkg;
    // Which write port updates a given register in a cycle.
    typedef enum logic [1:0] {
        WSRC_NONE  = 2'd0,
        WSRC_ALU   = 2'd1,
        WSRC_LOAD  = 2'd2,
        WSRC_PLAIN = 2'd3
    } wsrc_e;
endpackage

// File: rtl/dxt_src_tok.sv
// Combines the stored tokens of two ALU sources into the result token.
// Assumes: tok_q[0] is tied to 0, so register 0 never poisons a result.
module dxt_src_tok #(
    parameter int NREG = 32,
    localparam int IW = $clog2(NREG)
) (
    input  logic [NREG-1:0] tok_q,
    input  logic [IW-1:0]   src_a,
    input  logic [IW-1:0]   src_b,
    output logic            res_tok
);
    // The result is poisoned if either source is poisoned.
    always_comb res_tok = tok_q[src_a] | tok_q[src_b];
endmodule

// File: rtl/dxt_regfile.sv
// Data and token storage with three prioritised write ports and one read port.
// Assumes: the ports may target the same register; plain > load > ALU.
// Register 0 is constant zero with a clear token.
// tok_d exposes each register's next token, for the check bypass.
module dxt_regfile
    import dxt_pkg::*;
#(
    parameter int NREG = 32,
    parameter int XLEN = 64,
    localparam int IW = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sl_vld,
    input  logic [IW-1:0]              sl_dst,
    input  logic                       sl_fault,
    input  logic [XLEN-1:0]            sl_data,
    input  logic                       op_vld,
    input  logic [IW-1:0]              op_dst,
    input  logic                       op_tok,
    input  logic [XLEN-1:0]            op_data,
    input  logic                       nw_vld,
    input  logic [IW-1:0]              nw_dst,
    input  logic [XLEN-1:0]            nw_data,
    input  logic [IW-1:0]              rp_idx,
    output logic [XLEN-1:0]            rp_data,
    output logic                       rp_tok,
    output logic [NREG-1:0]            tok_q,
    output logic [NREG-1:0]            tok_d
);
    logic [NREG-1:0][XLEN-1:0] dat_q;

    assign dat_q[0] = '0;
    assign tok_q[0] = 1'b0;
    assign tok_d[0] = 1'b0;

    for (genvar i = 1; i < NREG; i++) begin : g_reg
        wsrc_e           sel;
        logic [XLEN-1:0] d_q, d_n;
        logic            t_q, t_n;

        // Pick the winning write port for this register.
        always_comb begin
            sel = WSRC_NONE;
            if (op_vld && op_dst == IW'(i)) sel = WSRC_ALU;
            if (sl_vld && sl_dst == IW'(i)) sel = WSRC_LOAD;
            if (nw_vld && nw_dst == IW'(i)) sel = WSRC_PLAIN;
        end

        // Form next data and token from the winning port.
        always_comb begin
            d_n = d_q;
            t_n = t_q;
            unique case (sel)
                WSRC_ALU:   begin d_n = op_data; t_n = op_tok; end
                WSRC_LOAD:  begin d_n = sl_fault ? '0 : sl_data; t_n = sl_fault; end
                WSRC_PLAIN: begin d_n = nw_data; t_n = 1'b0; end
                default:    ;
            endcase
        end

        // Hold or update the register state.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                d_q <= '0;
                t_q <= 1'b0;
            end else begin
                d_q <= d_n;
                t_q <= t_n;
            end
        end

        assign dat_q[i] = d_q;
        assign tok_q[i] = t_q;
        assign tok_d[i] = t_n;
    end

    // Combinational read of stored state.
    always_comb begin
        rp_data = dat_q[rp_idx];
        rp_tok  = tok_q[rp_idx];
    end
endmodule

// File: rtl/dxt_chk.sv
// Check unit: tests the write-first token of the checked register and
// registers a one-cycle recovery redirect carrying the index.
// Assumes: tok_d[0] is 0, so checks on register 0 never redirect.
module dxt_chk #(
    parameter int NREG = 32,
    localparam int IW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ck_vld,
    input  logic [IW-1:0]   ck_reg,
    input  logic [NREG-1:0] tok_d,
    output logic            rc_vld,
    output logic [IW-1:0]   rc_reg
);
    logic hit;

    // A check fails when the token after this cycle's writes is set.
    always_comb hit = ck_vld & tok_d[ck_reg];

    // Raise the redirect for one cycle per failing check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rc_vld <= 1'b0;
            rc_reg <= '0;
        end else begin
            rc_vld <= hit;
            rc_reg <= hit ? ck_reg : '0;
        end
    end
endmodule

// File: rtl/dxt_tracker.sv
// Top level of the deferred-exception tracker: register file with
// per-register poison tokens, token propagation for ALU results, and
// speculation checks that raise a recovery redirect.
// Assumes: one write per port per cycle; all indices are in range.
module dxt_tracker #(
    parameter int NREG = 32,
    parameter int XLEN = 64,
    localparam int IW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sl_vld,
    input  logic [IW-1:0]   sl_dst,
    input  logic            sl_fault,
    input  logic [XLEN-1:0] sl_data,
    input  logic            op_vld,
    input  logic [IW-1:0]   op_dst,
    input  logic [IW-1:0]   op_src_a,
    input  logic [IW-1:0]   op_src_b,
    input  logic [XLEN-1:0] op_data,
    input  logic            nw_vld,
    input  logic [IW-1:0]   nw_dst,
    input  logic [XLEN-1:0] nw_data,
    input  logic            ck_vld,
    input  logic [IW-1:0]   ck_reg,
    input  logic [IW-1:0]   rp_idx,
    output logic [XLEN-1:0] rp_data,
    output logic            rp_tok,
    output logic            rc_vld,
    output logic [IW-1:0]   rc_reg
);
    logic [NREG-1:0] tok_q;
    logic [NREG-1:0] tok_d;
    logic            op_tok;

    dxt_src_tok #(.NREG(NREG)) u_src (
        .tok_q   (tok_q),
        .src_a   (op_src_a),
        .src_b   (op_src_b),
        .res_tok (op_tok)
    );

    dxt_regfile #(.NREG(NREG), .XLEN(XLEN)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .sl_vld   (sl_vld),
        .sl_dst   (sl_dst),
        .sl_fault (sl_fault),
        .sl_data  (sl_data),
        .op_vld   (op_vld),
        .op_dst   (op_dst),
        .op_tok   (op_tok),
        .op_data  (op_data),
        .nw_vld   (nw_vld),
        .nw_dst   (nw_dst),
        .nw_data  (nw_data),
        .rp_idx   (rp_idx),
        .rp_data  (rp_data),
        .rp_tok   (rp_tok),
        .tok_q    (tok_q),
        .tok_d    (tok_d)
    );

    dxt_chk #(.NREG(NREG)) u_chk (
        .clk    (clk),
        .rst_n  (rst_n),
        .ck_vld (ck_vld),
        .ck_reg (ck_reg),
        .tok_d  (tok_d),
        .rc_vld (rc_vld),
        .rc_reg (rc_reg)
    );
endmodule

// File: rtl/dxt_tracker_sva.sv
// Port-level properties of the tracker, bound to every dxt_tracker instance.
// Assumes: synchronous active-low reset; all properties are off during reset.
module dxt_tracker_sva #(
    parameter int NREG = 32,
    parameter int XLEN = 64,
    localparam int IW = $clog2(NREG)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sl_vld,
    input logic [IW-1:0]   sl_dst,
    input logic            sl_fault,
    input logic [XLEN-1:0] sl_data,
    input logic            op_vld,
    input logic [IW-1:0]   op_dst,
    input logic [IW-1:0]   op_src_a,
    input logic [IW-1:0]   op_src_b,
    input logic [XLEN-1:0] op_data,
    input logic            nw_vld,
    input logic [IW-1:0]   nw_dst,
    input logic [XLEN-1:0] nw_data,
    input logic            ck_vld,
    input logic [IW-1:0]   ck_reg,
    input logic [IW-1:0]   rp_idx,
    input logic [XLEN-1:0] rp_data,
    input logic            rp_tok,
    input logic            rc_vld,
    input logic [IW-1:0]   rc_reg
);
    AST_RC_AFTER_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        rc_vld |-> $past(ck_vld) && rc_reg == $past(ck_reg)); // R7

    AST_RC_NOT_X0: assert property (@(posedge clk) disable iff (!rst_n)
        rc_vld |-> rc_reg != '0); // R9

    AST_X0_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        rp_idx == '0 |-> rp_data == '0 && !rp_tok); // R9

    AST_PLAIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(nw_vld) && $past(nw_dst) != '0 && rp_idx == $past(nw_dst))
        |-> !rp_tok && rp_data == $past(nw_data)); // R5

    AST_FAULT_POISONS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sl_vld && sl_fault && sl_dst != '0 && !(nw_vld && nw_dst == sl_dst))
         && rp_idx == $past(sl_dst)) |-> rp_tok && rp_data == '0); // R3

    AST_CLEAN_NO_RC: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_vld && ck_reg == '0) |=> !rc_vld); // R9
endmodule

bind dxt_tracker dxt_tracker_sva #(.NREG(NREG), .XLEN(XLEN)) u_sva (.*);

// File: tb/sim_dxt_tracker.sv
// Bench: behavioural reference model compared every cycle, plus directed cases.
module sim_dxt_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 32;
    localparam int XLEN = 64;
    localparam int IW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sl_vld, sl_fault, op_vld, nw_vld, ck_vld;
    logic [IW-1:0] sl_dst, op_dst, op_src_a, op_src_b, nw_dst, ck_reg, rp_idx;
    logic [XLEN-1:0] sl_data, op_data, nw_data;
    logic [XLEN-1:0] rp_data;
    logic rp_tok, rc_vld;
    logic [IW-1:0] rc_reg;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dxt_tracker #(.NREG(NREG), .XLEN(XLEN)) u0 (.*);

    // Reference model state
    logic [XLEN-1:0] m_dat [NREG];
    logic            m_tok [NREG];
    logic [XLEN-1:0] n_dat [NREG];
    logic            n_tok [NREG];
    logic            m_rc;
    logic [IW-1:0]   m_rcr;
    logic            src_t;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin m_dat[i] = '0; m_tok[i] = 0; end
            m_rc = 0; m_rcr = '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin n_dat[i] = m_dat[i]; n_tok[i] = m_tok[i]; end
            src_t = m_tok[op_src_a] | m_tok[op_src_b];
            if (op_vld) begin n_dat[op_dst] = op_data; n_tok[op_dst] = src_t; end
            if (sl_vld) begin n_dat[sl_dst] = sl_fault ? '0 : sl_data; n_tok[sl_dst] = sl_fault; end
            if (nw_vld) begin n_dat[nw_dst] = nw_data; n_tok[nw_dst] = 0; end
            n_dat[0] = '0; n_tok[0] = 0;
            m_rc  = ck_vld && n_tok[ck_reg];
            m_rcr = m_rc ? ck_reg : '0;
            for (int i = 0; i < NREG; i++) begin m_dat[i] = n_dat[i]; m_tok[i] = n_tok[i]; end
        end
    end

    task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R11 rp_data", rp_data, m_dat[rp_idx]);
            chk("R11 rp_tok", 64'(rp_tok), 64'(m_tok[rp_idx]));
            chk("R7 rc_vld", 64'(rc_vld), 64'(m_rc));
            if (m_rc) chk("R7 rc_reg", 64'(rc_reg), 64'(m_rcr));
        end
    end

    task automatic idle();
        sl_vld = 0; sl_fault = 0; sl_dst = '0; sl_data = '0;
        op_vld = 0; op_dst = '0; op_src_a = '0; op_src_b = '0; op_data = '0;
        nw_vld = 0; nw_dst = '0; nw_data = '0;
        ck_vld = 0; ck_reg = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #1 idle();
    endtask

    task automatic expect_reg(input string tag, input int idx, input logic [XLEN-1:0] d, input logic t);
        rp_idx = IW'(idx);
        #1;
        chk(tag, rp_data, d);
        chk(tag, 64'(rp_tok), 64'(t));
    endtask

    task automatic expect_rc(input string tag, input logic v, input int idx);
        chk(tag, 64'(rc_vld), 64'(v));
        if (v) chk(tag, 64'(rc_reg), 64'(idx));
    endtask

    task automatic do_load(input int d, input logic f, input logic [XLEN-1:0] v);
        sl_vld = 1; sl_dst = IW'(d); sl_fault = f; sl_data = v;
    endtask

    task automatic do_op(input int d, input int a, input int b, input logic [XLEN-1:0] v);
        op_vld = 1; op_dst = IW'(d); op_src_a = IW'(a); op_src_b = IW'(b); op_data = v;
    endtask

    task automatic do_plain(input int d, input logic [XLEN-1:0] v);
        nw_vld = 1; nw_dst = IW'(d); nw_data = v;
    endtask

    task automatic do_check(input int r);
        ck_vld = 1; ck_reg = IW'(r);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle();
        rp_idx = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        expect_reg("R1 reset", 5, '0, 0);
        expect_rc("R1 reset rc", 0, 0);

        do_load(3, 0, 64'hAAAA); tick();
        expect_reg("R2 clean load", 3, 64'hAAAA, 0);

        do_load(4, 1, 64'h1234); tick();
        expect_reg("R3 faulting load", 4, '0, 1);
        expect_rc("R3 no trap", 0, 0);

        do_op(6, 3, 4, 64'h77); tick();
        expect_reg("R4 poisoned source", 6, 64'h77, 1);
        do_op(7, 3, 0, 64'h55); tick();
        expect_reg("R4 clean sources", 7, 64'h55, 0);

        do_check(3); tick();
        expect_rc("R6 clean check", 0, 0);
        do_check(6); tick();
        expect_rc("R7 failing check", 1, 6);
        tick();
        expect_rc("R7 one cycle", 0, 0);

        do_plain(4, 64'h99); tick();
        expect_reg("R5 plain write", 4, 64'h99, 0);

        do_load(8, 1, 64'h1); do_check(8); tick();
        expect_rc("R8 bypass set", 1, 8);
        do_plain(6, 64'h3); do_check(6); tick();
        expect_rc("R8 bypass clear", 0, 0);

        do_load(0, 1, 64'h5); tick();
        expect_reg("R9 x0 write", 0, '0, 0);
        do_check(0); tick();
        expect_rc("R9 x0 check", 0, 0);

        do_op(9, 8, 0, 64'h1); do_load(9, 0, 64'h2); tick();
        expect_reg("R10 load over alu", 9, 64'h2, 0);
        do_load(10, 1, 64'h7); do_plain(10, 64'h3); tick();
        expect_reg("R10 plain over load", 10, 64'h3, 0);

        // Random traffic on a narrow index range to force collisions.
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(1, 0) == 1) do_load($urandom_range(7, 0), $urandom_range(2, 0) == 0, {$urandom, $urandom});
            if ($urandom_range(1, 0) == 1) do_op($urandom_range(7, 0), $urandom_range(7, 0), $urandom_range(7, 0), {$urandom, $urandom});
            if ($urandom_range(3, 0) == 0) do_plain($urandom_range(7, 0), {$urandom, $urandom});
            if ($urandom_range(1, 0) == 1) do_check($urandom_range(7, 0));
            rp_idx = IW'($urandom_range(7, 0));
            tick();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule